// File: doc/BRIEF.md
# Protection Region Bounds Decoder

This block turns one protection entry's settings into the byte-address range that the entry covers. It takes three inputs: a two-bit match mode, the entry's own address register, and the address register of the entry just below it. Address registers hold a byte address divided by four. The block returns an inclusive start and end byte address and a flag that marks the entry as live. The block is purely combinational, so the range follows the inputs within the same cycle.

One copy is built for each entry of a protection unit. The bottom entry is built with `FIRST_ENTRY` set, so it sees a lower bound of zero. Each other entry takes its neighbour's address register on `prev_addr_i`. The outputs are two bits wider than the address registers, so the whole byte space can be expressed.

Top module: `pmp_bounds_decoder`

## Requirements
- R1: Mode code 0 (off) drives `en_o` low and both bounds to zero.
- R2: Mode code 1 (top-of-range) gives start = `prev_addr_i`×4 and end = `addr_i`×4 − 1, taken modulo 2^(AW+2). An own address of zero therefore wraps the end to all ones.
- R3: In mode code 1, when the computed start exceeds the computed end (including `prev_addr_i` == `addr_i`), both bounds are forced to zero.
- R4: When `FIRST_ENTRY` is 1, the lower neighbour is taken as zero whatever `prev_addr_i` carries.
- R5: Mode code 2 (aligned four bytes) gives start = `addr_i`×4 and end = start + 3.
- R6: Mode code 3 (aligned power of two) with `addr_i` bit 0 clear gives an 8-byte region starting at (`addr_i`×4) with the low three bits cleared.
- R7: In mode code 3, k trailing ones in `addr_i` give a region of 2^(k+3) bytes. The region is aligned to its own size and contains `addr_i`×4.
- R8: In mode code 3, an `addr_i` of AW−1 or more trailing ones gives the full range: start zero, end all ones.
- R9: `en_o` is high for every mode code other than 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mode_i | input | 2 | Match mode: 0 off, 1 top-of-range, 2 aligned four bytes, 3 aligned power of two |
| addr_i | input | AW | This entry's address register (byte address / 4) |
| prev_addr_i | input | AW | Lower neighbour's address register; ignored when FIRST_ENTRY is 1 |
| start_o | output | AW+2 | First byte address of the region (inclusive) |
| end_o | output | AW+2 | Last byte address of the region (inclusive) |
| en_o | output | 1 | Entry is live |

## Verification
The bench builds two copies with AW = 8: one as an ordinary entry and one as the bottom entry. With this small width, all 256 address values can be walked in the power-of-two mode, so every trailing-ones count from zero to all ones is reached, including the two full-range patterns. The aligned-four mode is also swept exhaustively. A grid of neighbour/own address pairs covers the top-of-range mode: ascending, equal and inverted pairs, and the own-address-zero wrap. The bottom entry is driven with nonzero neighbour values to show they are ignored.

// File: rtl/pmp_bounds_pkg.sv
package pmp_bounds_pkg;
  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_TOR   = 2'd1,
    MODE_NA4   = 2'd2,
    MODE_NAPOT = 2'd3
  } match_mode_e;
endpackage

// File: rtl/pmp_tor_range.sv
module pmp_tor_range #(
  parameter int AW = 8,
  localparam int OW = AW + 2
) (
  input  logic [AW-1:0] lo_addr_i,
  input  logic [AW-1:0] hi_addr_i,
  output logic [OW-1:0] start_o,
  output logic [OW-1:0] end_o
);
  logic [OW-1:0] raw_start, raw_end;

  always_comb begin
    raw_start = {lo_addr_i, 2'b00};
    raw_end   = {hi_addr_i, 2'b00} - OW'(1);
    if (raw_start > raw_end) begin
      start_o = '0;
      end_o   = '0;
    end else begin
      start_o = raw_start;
      end_o   = raw_end;
    end
  end

  always_comb begin
    if (!$isunknown({lo_addr_i, hi_addr_i})) begin
      p_tor_order_r3: assert (start_o <= end_o)
        else $error("tor bounds out of order");
      p_tor_empty_r3: assert (!(lo_addr_i >= hi_addr_i && hi_addr_i != '0) ||
                              (start_o == '0 && end_o == '0))
        else $error("inverted tor range not collapsed");
    end
  end
endmodule

// File: rtl/pmp_na4_range.sv
module pmp_na4_range #(
  parameter int AW = 8,
  localparam int OW = AW + 2
) (
  input  logic [AW-1:0] addr_i,
  output logic [OW-1:0] start_o,
  output logic [OW-1:0] end_o
);
  assign start_o = {addr_i, 2'b00};
  assign end_o   = {addr_i, 2'b11};

  always_comb begin
    if (!$isunknown(addr_i)) begin
      p_na4_span_r5: assert (end_o - start_o == OW'(3))
        else $error("na4 span not four bytes");
    end
  end
endmodule

// File: rtl/pmp_napot_range.sv
module pmp_napot_range #(
  parameter int AW = 8,
  localparam int OW = AW + 2
) (
  input  logic [AW-1:0] addr_i,
  output logic [OW-1:0] start_o,
  output logic [OW-1:0] end_o
);
  logic [OW-1:0] ext, ext_inc, span;

  // carry of +1 runs through the trailing ones and marks the size
  assign ext     = {addr_i, 2'b11};
  assign ext_inc = ext + OW'(1);
  assign start_o = ext & ext_inc;
  assign end_o   = ext | ext_inc;
  assign span    = start_o ^ end_o;

  always_comb begin
    if (!$isunknown(addr_i)) begin
      p_napot_min_r6: assert (span[2:0] == 3'b111)
        else $error("napot region below eight bytes");
      p_napot_pow2_r7: assert (((span & (span + OW'(1))) == '0) && ((start_o & span) == '0))
        else $error("napot region not aligned power of two");
    end
  end
endmodule

// File: rtl/pmp_bounds_decoder.sv
module pmp_bounds_decoder
  import pmp_bounds_pkg::*;
#(
  parameter int AW          = 8,
  parameter bit FIRST_ENTRY = 1'b0,
  localparam int OW = AW + 2
) (
  input  logic [1:0]    mode_i,
  input  logic [AW-1:0] addr_i,
  input  logic [AW-1:0] prev_addr_i,
  output logic [OW-1:0] start_o,
  output logic [OW-1:0] end_o,
  output logic          en_o
);
  logic [AW-1:0] lo_addr;
  logic [OW-1:0] tor_s, tor_e, na4_s, na4_e, npt_s, npt_e;
  match_mode_e   mode;

  assign mode = match_mode_e'(mode_i);

  generate
    if (FIRST_ENTRY) begin : g_bottom
      assign lo_addr = '0;
    end else begin : g_chain
      assign lo_addr = prev_addr_i;
    end
  endgenerate

  pmp_tor_range #(.AW(AW)) u_tor (
    .lo_addr_i (lo_addr),
    .hi_addr_i (addr_i),
    .start_o   (tor_s),
    .end_o     (tor_e)
  );

  pmp_na4_range #(.AW(AW)) u_na4 (
    .addr_i  (addr_i),
    .start_o (na4_s),
    .end_o   (na4_e)
  );

  pmp_napot_range #(.AW(AW)) u_napot (
    .addr_i  (addr_i),
    .start_o (npt_s),
    .end_o   (npt_e)
  );

  always_comb begin
    en_o    = 1'b1;
    start_o = '0;
    end_o   = '0;
    unique case (mode)
      MODE_TOR:   begin start_o = tor_s; end_o = tor_e; end
      MODE_NA4:   begin start_o = na4_s; end_o = na4_e; end
      MODE_NAPOT: begin start_o = npt_s; end_o = npt_e; end
      default:    en_o = 1'b0;
    endcase
  end

  always_comb begin
    if (!$isunknown(mode_i)) begin
      p_off_zero_r1: assert (en_o || (start_o == '0 && end_o == '0))
        else $error("disabled entry with nonzero bounds");
      p_live_flag_r9: assert (en_o == (mode_i != 2'd0))
        else $error("enable flag disagrees with mode");
    end
  end
endmodule

// File: tb/pmp_bounds_decoder_tb.sv
module pmp_bounds_decoder_tb;
  localparam int AW = 8;
  localparam int OW = AW + 2;
  localparam logic [63:0] MASK = (64'd1 << OW) - 64'd1;

  typedef struct {
    string         tag;
    bit            sel_first;
    logic [OW-1:0] exp_s;
    logic [OW-1:0] exp_e;
    logic          exp_en;
  } item_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk;

  logic [1:0]    mode;
  logic [AW-1:0] addr, prev;
  logic [OW-1:0] s0, e0, s1, e1;
  logic          en0, en1;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  item_t q[$];

  pmp_bounds_decoder #(.AW(AW), .FIRST_ENTRY(1'b0)) u_dut (
    .mode_i(mode), .addr_i(addr), .prev_addr_i(prev),
    .start_o(s0), .end_o(e0), .en_o(en0));

  pmp_bounds_decoder #(.AW(AW), .FIRST_ENTRY(1'b1)) u_dut_first (
    .mode_i(mode), .addr_i(addr), .prev_addr_i(prev),
    .start_o(s1), .end_o(e1), .en_o(en1));

  task automatic drive(input string tag, input bit sel, input logic [1:0] m,
                       input logic [AW-1:0] a, input logic [AW-1:0] p,
                       input logic [63:0] es, input logic [63:0] ee, input logic een);
    item_t it;
    @(posedge clk);
    mode = m; addr = a; prev = p;
    it.tag = tag; it.sel_first = sel;
    it.exp_s = es[OW-1:0]; it.exp_e = ee[OW-1:0]; it.exp_en = een;
    q.push_back(it);
  endtask

  task automatic tor_exp(input logic [AW-1:0] lo, input logic [AW-1:0] hi,
                         output logic [63:0] es, output logic [63:0] ee);
    es = 64'(lo) * 4;
    ee = (64'(hi) * 4 - 64'd1) & MASK;
    if (es > ee) begin es = 0; ee = 0; end
  endtask

  // monitor: compare one result per cycle away from the driving edge
  always @(negedge clk) begin
    if (rst_ni && q.size() > 0) begin
      item_t it;
      logic [OW-1:0] gs, ge;
      logic gen;
      it = q.pop_front();
      gs  = it.sel_first ? s1 : s0;
      ge  = it.sel_first ? e1 : e0;
      gen = it.sel_first ? en1 : en0;
      checks++;
      if (gs !== it.exp_s || ge !== it.exp_e || gen !== it.exp_en) begin
        errors++;
        $display("FAIL %s: got start=%h end=%h en=%b, expected start=%h end=%h en=%b",
                 it.tag, gs, ge, gen, it.exp_s, it.exp_e, it.exp_en);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] es, ee;
    mode = 2'd0; addr = '0; prev = '0;
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;

    // R1: off mode, several addresses, both copies
    drive("R1 off", 1'b0, 2'd0, 8'h00, 8'h00, 0, 0, 1'b0);
    drive("R1 off", 1'b0, 2'd0, 8'hA5, 8'h3C, 0, 0, 1'b0);
    drive("R1 off first", 1'b1, 2'd0, 8'hFF, 8'hFF, 0, 0, 1'b0);

    // R5 R9: aligned four bytes, exhaustive
    for (int a = 0; a < 256; a++)
      drive("R5 na4", 1'b0, 2'd2, AW'(a), 8'h11, 64'(a) * 4, 64'(a) * 4 + 3, 1'b1);

    // R6 R7 R8 R9: power of two, exhaustive against trailing-ones size
    for (int a = 0; a < 256; a++) begin
      int k;
      logic [63:0] sz;
      k = 0;
      while (k < AW && a[k]) k++;
      sz = 64'd1 << (k + 3);
      es = (64'(a) * 4) & ~(sz - 64'd1) & MASK;
      ee = (es + sz - 64'd1) & MASK;
      if (k >= AW - 1)
        drive("R8 napot full", 1'b0, 2'd3, AW'(a), 8'h00, es, ee, 1'b1);
      else if (k == 0)
        drive("R6 napot eight", 1'b0, 2'd3, AW'(a), 8'h00, es, ee, 1'b1);
      else
        drive("R7 napot pow2", 1'b0, 2'd3, AW'(a), 8'h00, es, ee, 1'b1);
    end

    // R2 R3: top-of-range grid incl. equal, inverted and own-zero wrap
    for (int p = 0; p < 256; p += 17) begin
      for (int h = 0; h < 256; h += 15) begin
        tor_exp(AW'(p), AW'(h), es, ee);
        if (es == 0 && ee == 0 && p != 0)
          drive("R3 tor inverted", 1'b0, 2'd1, AW'(h), AW'(p), es, ee, 1'b1);
        else
          drive("R2 tor", 1'b0, 2'd1, AW'(h), AW'(p), es, ee, 1'b1);
      end
    end
    tor_exp(8'h40, 8'h40, es, ee);
    drive("R3 tor equal", 1'b0, 2'd1, 8'h40, 8'h40, es, ee, 1'b1);
    tor_exp(8'h41, 8'h40, es, ee);
    drive("R3 tor one below", 1'b0, 2'd1, 8'h40, 8'h41, es, ee, 1'b1);
    tor_exp(8'h00, 8'h00, es, ee);
    drive("R2 tor own zero wrap", 1'b0, 2'd1, 8'h00, 8'h00, es, ee, 1'b1);

    // R4: bottom entry ignores neighbour value
    for (int p = 1; p < 256; p += 37) begin
      tor_exp(8'h00, 8'h20, es, ee);
      drive("R4 bottom tor", 1'b1, 2'd1, 8'h20, AW'(p), es, ee, 1'b1);
    end
    tor_exp(8'h00, 8'h01, es, ee);
    drive("R4 bottom tor small", 1'b1, 2'd1, 8'h01, 8'hFF, es, ee, 1'b1);

    // R9: enable follows mode on the bottom copy too
    drive("R9 bottom na4", 1'b1, 2'd2, 8'h07, 8'h99, 64'h1C, 64'h1F, 1'b1);

    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule